// File: doc/BRIEF.md
# Maskable PHY Event Interrupt Collector

This block turns a fixed set of single-cycle event pulses from a network PHY into sticky status bits and drives one interrupt pin from them. The host does not need to poll the link: it waits for the pin, then reads the status word to learn which events fired. Reading the status word returns the latched events and clears them in the same access.

Each status bit has a matching enable bit. A control register adds a global gate on top of the per-event enables, and a polarity bit that selects whether the pin signals an interrupt by going low (the reset default) or by going high. A small register port with read and write strobes sits in front of the registers. The serial management framing and the event detectors are outside this block.

Top module: `phy_irq_collector`

## Requirements
- R1: After a synchronous reset all status bits are 0, all enable bits are 0, the control register is 0 (global gate off, active-low polarity) and the pin is driven high.
- R2: A one-cycle pulse on event input i sets status bit i, and the bit stays set until the status word is read. Bit order: 0 receive error, 1 jabber, 2 page received, 3 parallel detect fault, 4 partner acknowledge, 5 link change, 6 negotiation done, 7 remote fault, 8 collision.
- R3: With reg_addr = 0 and reg_rd high, reg_rdata shows the status word during that cycle and every status bit is 0 in the next cycle unless R4 applies.
- R4: An event pulse in the same cycle as a status read leaves its bit set after the read.
- R5: Address 1 is the enable register: a write stores reg_wdata and reg_rdata returns the stored value.
- R6: Address 2 is the control register: bit 0 is the global gate, bit 1 the polarity (1 = active high); a write keeps only those two bits and the other bits read as 0.
- R7: The interrupt is active when the global gate is 1 and at least one status bit is set whose enable bit is 1; the pin reflects that state one clock after it is reached.
- R8: With polarity 0 an active interrupt drives the pin low and an inactive one high; with polarity 1 the levels are swapped.
- R9: Writes to address 0 and address 3 change no register, and address 3 reads as 0.
- R10: Reads of addresses 1, 2 and 3 with reg_rd high leave the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | NUM_EVT | One-cycle event pulses, one per event |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 control, 3 unused |
| reg_rd | input | 1 | Read strobe; with address 0 it clears the status |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | NUM_EVT | Write data |
| reg_rdata | output | NUM_EVT | Read data for the selected register, valid in the strobe cycle |
| irq_pin | output | 1 | Interrupt pin, polarity per control bit 1 |

## Verification
The hardest situation to reach from the ports is an event pulse landing in exactly the cycle of a status read, since a missed bit there is silent until the next event of the same kind. The stimulus schedules the pulse and the read strobe in the same cycle for a single bit and for several bits, with other bits already pending, and then checks the status word and the pin in the following cycles. Polarity flips while an interrupt is pending and the global gate toggling with status held set are also driven, so the pin must follow the control register rather than the events alone.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    // Packed so that gate sits at bit 0 and polarity at bit 1
    typedef struct packed {
        logic act_high;
        logic gate;
    } irq_ctrl_t;

    localparam int CTRL_W = $bits(irq_ctrl_t);

    // Pin level for a given interrupt state and polarity
    function automatic logic pin_level(input logic active, input logic act_high);
        return act_high ? active : ~active;
    endfunction

endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
    parameter int NUM_EVT = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               clr,
    output logic [NUM_EVT-1:0] status
);

    logic [NUM_EVT-1:0] st_q;

    generate
        for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    st_q[i] <= 1'b0;
                else if (evt[i])
                    st_q[i] <= 1'b1;
                else if (clr)
                    st_q[i] <= 1'b0;
            end
        end
    endgenerate

    assign status = st_q;

    // R2: a pulse always leaves its bit set
    a_r2_evt_sets: assert property (@(posedge clk) disable iff (rst)
        |evt |=> ((st_q & $past(evt)) == $past(evt)));

    // R2: without a clearing read nothing drops
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((st_q & $past(st_q)) == $past(st_q)));

    // R3/R4: after a clear only same-cycle events remain
    a_r3_clear_keeps_new: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st_q == $past(evt)));

endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
    import phy_irq_pkg::*;
#(
    parameter int NUM_EVT = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         addr,
    input  logic               rd,
    input  logic               wr,
    input  logic [NUM_EVT-1:0] wdata,
    input  logic [NUM_EVT-1:0] status,
    output logic [NUM_EVT-1:0] rdata,
    output logic [NUM_EVT-1:0] enable,
    output irq_ctrl_t          ctrl,
    output logic               status_clr
);

    reg_sel_e           sel;
    logic [NUM_EVT-1:0] en_q;
    irq_ctrl_t          ctrl_q;

    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            ctrl_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_ENABLE: en_q   <= wdata;
                SEL_CTRL:   ctrl_q <= irq_ctrl_t'(wdata[CTRL_W-1:0]);
                default:    ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_STATUS: rdata = status;
            SEL_ENABLE: rdata = en_q;
            SEL_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
            default:    rdata = '0;
        endcase
    end

    assign status_clr = rd && (sel == SEL_STATUS);
    assign enable     = en_q;
    assign ctrl       = ctrl_q;

    // R9: writes to status or spare address leave enable and control alone
    a_r9_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr && (sel == SEL_STATUS || sel == SEL_SPARE)) |=> ($stable(en_q) && $stable(ctrl_q)));

    // R5: no write, no change
    a_r5_enable_holds: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(en_q));

endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
    import phy_irq_pkg::*;
#(
    parameter int NUM_EVT = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] status,
    input  logic [NUM_EVT-1:0] enable,
    input  irq_ctrl_t          ctrl,
    output logic               pin
);

    logic active;
    logic pin_q;

    assign active = ctrl.gate && (|(status & enable));

    always_ff @(posedge clk) begin
        if (rst)
            pin_q <= 1'b1;
        else
            pin_q <= pin_level(active, ctrl.act_high);
    end

    assign pin = pin_q;

endmodule

// File: rtl/phy_irq_collector.sv
module phy_irq_collector
    import phy_irq_pkg::*;
#(
    parameter int NUM_EVT = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [1:0]         reg_addr,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [NUM_EVT-1:0] reg_wdata,
    output logic [NUM_EVT-1:0] reg_rdata,
    output logic               irq_pin
);

    logic [NUM_EVT-1:0] status;
    logic [NUM_EVT-1:0] enable;
    irq_ctrl_t          ctrl;
    logic               status_clr;

    irq_evt_latch #(.NUM_EVT(NUM_EVT)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_pulse),
        .clr    (status_clr),
        .status (status)
    );

    irq_reg_file #(.NUM_EVT(NUM_EVT)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr       (reg_addr),
        .rd         (reg_rd),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .status     (status),
        .rdata      (reg_rdata),
        .enable     (enable),
        .ctrl       (ctrl),
        .status_clr (status_clr)
    );

    irq_pin_drive #(.NUM_EVT(NUM_EVT)) u_pin (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .enable (enable),
        .ctrl   (ctrl),
        .pin    (irq_pin)
    );

    // R7/R8: pending enabled event under the gate shows the active level
    a_r7_pin_active: assert property (@(posedge clk) disable iff (rst)
        (ctrl.gate && (|(status & enable))) |=> (irq_pin == $past(ctrl.act_high)));

    // R7/R8: otherwise the pin rests at the inactive level
    a_r8_pin_idle: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.gate && (|(status & enable))) |=> (irq_pin == !$past(ctrl.act_high)));

    // R10: non-status reads never clear
    a_r10_other_read: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr != 2'd0) |=> ((status & $past(status)) == $past(status)));

endmodule

// File: tb/phy_irq_collector_test.sv
module phy_irq_collector_test;

    localparam int N = 9;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] evt_pulse = '0;
    logic [1:0]   reg_addr = 2'd0;
    logic         reg_rd = 1'b0;
    logic         reg_wr = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_pin;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference state
    logic [N-1:0] m_st = '0;
    logic [N-1:0] m_en = '0;
    logic         m_gate = 1'b0;
    logic         m_hi = 1'b0;
    logic         m_pin = 1'b1;

    always #10 clk = ~clk;

    phy_irq_collector #(.NUM_EVT(N)) uut (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_pin(irq_pin)
    );

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_st = '0; m_en = '0; m_gate = 0; m_hi = 0; m_pin = 1;
        end else begin
            bit act;
            logic [N-1:0] st_n;
            act = m_gate && ((m_st & m_en) != 0);
            st_n = ((reg_rd && reg_addr == 2'd0) ? '0 : m_st) | evt_pulse;
            m_pin = m_hi ? act : !act;
            if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata;
            if (reg_wr && reg_addr == 2'd2) begin
                m_gate = reg_wdata[0];
                m_hi = reg_wdata[1];
            end
            m_st = st_n;
        end
    end

    function automatic logic [N-1:0] exp_rdata();
        case (reg_addr)
            2'd0: return m_st;
            2'd1: return m_en;
            2'd2: return {{(N-2){1'b0}}, m_hi, m_gate};
            default: return '0;
        endcase
    endfunction

    task automatic check(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // every cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(cur_req, "pin", {{(N-1){1'b0}}, irq_pin}, {{(N-1){1'b0}}, m_pin});
            check(cur_req, "rdata", reg_rdata, exp_rdata());
        end
    end

    task automatic drive(logic [N-1:0] e, logic [1:0] a, logic r, logic w, logic [N-1:0] d);
        @(posedge clk); #2;
        evt_pulse = e; reg_addr = a; reg_rd = r; reg_wr = w; reg_wdata = d;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) drive('0, 2'd0, 0, 0, '0);
    endtask

    task automatic peek(logic [1:0] a);
        drive('0, a, 0, 0, '0);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        fails++; tests++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R1: reset values
        @(negedge clk);
        check("R1", "pin after reset", {{(N-1){1'b0}}, irq_pin}, {{(N-1){1'b0}}, 1'b1});
        check("R1", "status after reset", reg_rdata, '0);
        peek(2'd1); @(negedge clk);
        check("R1", "enable after reset", reg_rdata, '0);
        peek(2'd2); @(negedge clk);
        check("R1", "ctrl after reset", reg_rdata, '0);

        // R2: each event sets its own bit and holds
        cur_req = "R2";
        for (int i = 0; i < N; i++) begin
            drive(N'(1) << i, 2'd0, 0, 0, '0);
            idle(2);
            @(negedge clk);
            check("R2", "sticky bit", reg_rdata, (N'(2) << i) - N'(1));
        end
        // R3: read clears
        cur_req = "R3";
        drive('0, 2'd0, 1, 0, '0);
        @(negedge clk);
        check("R3", "read returns status", reg_rdata, {N{1'b1}});
        idle(1); @(negedge clk);
        check("R3", "status cleared", reg_rdata, '0);

        // R5: enable register
        cur_req = "R5";
        drive('0, 2'd1, 0, 1, 9'h0A5);
        peek(2'd1); @(negedge clk);
        check("R5", "enable readback", reg_rdata, 9'h0A5);
        // R6: control register keeps two bits
        cur_req = "R6";
        drive('0, 2'd2, 0, 1, {N{1'b1}});
        peek(2'd2); @(negedge clk);
        check("R6", "ctrl readback", reg_rdata, 9'h003);
        drive('0, 2'd2, 0, 1, 9'h001);

        // R7/R8: masked vs enabled event, active low
        cur_req = "R7";
        drive(9'h002, 2'd0, 0, 0, '0);      // bit1 masked off
        idle(3); @(negedge clk);
        check("R7", "masked event idle pin", {{(N-1){1'b0}}, irq_pin}, {{(N-1){1'b0}}, 1'b1});
        drive(9'h004, 2'd0, 0, 0, '0);      // bit2 enabled
        idle(2); @(negedge clk);
        check("R8", "active low asserted", {{(N-1){1'b0}}, irq_pin}, '0);
        cur_req = "R8";
        drive('0, 2'd2, 0, 1, 9'h003);      // flip to active high
        idle(2); @(negedge clk);
        check("R8", "active high asserted", {{(N-1){1'b0}}, irq_pin}, {{(N-1){1'b0}}, 1'b1});
        cur_req = "R7";
        drive('0, 2'd2, 0, 1, 9'h002);      // gate off
        idle(2); @(negedge clk);
        check("R7", "gate off idle high-pol", {{(N-1){1'b0}}, irq_pin}, '0);
        drive('0, 2'd2, 0, 1, 9'h003);

        // R10: other reads do not clear
        cur_req = "R10";
        drive('0, 2'd1, 1, 0, '0);
        drive('0, 2'd2, 1, 0, '0);
        drive('0, 2'd3, 1, 0, '0);
        peek(2'd0); @(negedge clk);
        check("R10", "status kept", reg_rdata, 9'h006);

        // R4: event coincident with clearing read
        cur_req = "R4";
        drive(9'h100, 2'd0, 1, 0, '0);
        @(negedge clk);
        check("R4", "read value excludes new event", reg_rdata, 9'h006);
        idle(1); @(negedge clk);
        check("R4", "new event survives read", reg_rdata, 9'h100);
        drive(9'h0A0, 2'd0, 1, 0, '0);
        idle(1); @(negedge clk);
        check("R4", "multi-bit coincident", reg_rdata, 9'h0A0);
        drive('0, 2'd0, 1, 0, '0);
        idle(2); @(negedge clk);
        check("R7", "cleared pin idle", {{(N-1){1'b0}}, irq_pin}, '0);

        // R9: writes to status and spare are ignored
        cur_req = "R9";
        drive(9'h001, 2'd0, 0, 0, '0);
        drive('0, 2'd0, 0, 1, '0);
        drive('0, 2'd3, 0, 1, {N{1'b1}});
        @(negedge clk);
        check("R9", "spare reads zero", reg_rdata, '0);
        peek(2'd0); @(negedge clk);
        check("R9", "status unchanged", reg_rdata, 9'h001);
        peek(2'd1); @(negedge clk);
        check("R9", "enable unchanged", reg_rdata, 9'h0A5);
        peek(2'd2); @(negedge clk);
        check("R9", "ctrl unchanged", reg_rdata, 9'h003);

        // R1: reset mid-run
        cur_req = "R1";
        @(posedge clk); #2 rst = 1;
        repeat (2) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        check("R1", "pin after second reset", {{(N-1){1'b0}}, irq_pin}, {{(N-1){1'b0}}, 1'b1});
        check("R1", "status after second reset", reg_rdata, '0);
        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule